// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves bytes between serial time-division multiplexed streams. Two serial input streams form one input group, and two serial output streams form one output group. Each group runs at one of four bit rates. The receive side turns each input channel into a byte and stores it in a data memory with two halves. Within each frame, one half takes new bytes while the other holds the bytes of the frame before. A frame pulse resets the position count, so that channel 0, bit 0 follows it. All bits are shifted most significant bit first.

A connection memory holds one word per output channel, and software writes it through a simple write port. Each word decides what its output channel carries:
- the channel can be turned off, which gives high impedance on the enable output;
- it can be forced to all ones;
- it can send a fixed message byte;
- it can send a byte switched from any input stream and channel.

For switched bytes, each channel picks one of two delay modes. Constant delay keeps the bytes of a frame together by always reading the previous frame. Variable delay cuts latency by reading the current frame when the source byte has already arrived. The input rate and the output rate are set separately, so the block converts between rates.

Top module: `tsi_switch`

## Requirements
- R1: While reset is high, and after it, every output channel is disabled. tx_en and tx_data read 0 until the connection memory is written.
- R2: Rate code r (0 to 3, standing for 65.536, 32.768, 16.384 and 8.192 Mbit/s at full scale) makes each bit last 2^r clocks. It gives CH_MAX>>r channels per stream. A frame is 8*CH_MAX clocks. A high fp_in marks frame position 0.
- R3: Input bit b of channel c is sampled in the first clock of its slot, which starts at position (8c+b)<<r. Output bit b of channel c is visible in the clocks from start+1 to start+2^r. Bit 0 of a channel is the most significant bit.
- R4: A connection word is laid out as follows: bit 11 is output enable, bit 10 is force-high, bit 9 is message mode, bit 8 is variable delay, and bits 7:0 are the payload. A switched source uses payload[CHW] as the stream and payload[CHW-1:0] as the channel. The write address is {output stream, output channel}.
- R5: When the enable bit is 0, tx_en and tx_data are both 0 for the whole channel.
- R6: When force-high is set on an enabled channel, all 8 bits are 1. This overrides message mode and switched data.
- R7: Message mode on an enabled channel, with force-high clear, sends the payload byte.
- R8: Constant delay sends the source byte received in the previous frame.
- R9: Variable delay compares two slot starts: the output channel's bit-0 slot and the source channel's bit-7 slot. When the output start is later, it sends the byte from the current frame. Otherwise it sends the byte from the previous frame.
- R10: The input rate and the output rate are independent. Any pair of rate codes switches data correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per bit at the fastest rate |
| rst | input | 1 | Synchronous active-high reset |
| fp_in | input | 1 | Frame pulse; high marks position 0 |
| in_rate | input | 2 | Rate code of the input group |
| out_rate | input | 2 | Rate code of the output group |
| rx_data | input | 2 | Serial input streams |
| cm_we | input | 1 | Connection memory write strobe |
| cm_addr | input | CHW+1 | Connection address {stream, channel} |
| cm_wdata | input | 12 | Connection word |
| tx_data | output | 2 | Serial output streams |
| tx_en | output | 2 | Per-stream drive enable (0 = high impedance) |

## Verification
Two events can fall in the same frame region: writing a source byte into the current half, and loading an output channel that reads that byte in variable-delay mode. The sweep covers all 16 pairs of input and output rates. This places the output load just before, just after and far from the source's last-bit slot. Every output bit is then compared with the byte the bench expects, either from the current frame or from the previous one. The bench derives that choice from the slot arithmetic alone. A byte taken from the wrong half shows up as the neighbouring frame's value, because the bench makes each frame's data depend on the frame number.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    // Rate codes: a bit lasts 2**code clocks.
    typedef enum logic [1:0] {
        RATE_FULL    = 2'd0,
        RATE_HALF    = 2'd1,
        RATE_QUARTER = 2'd2,
        RATE_EIGHTH  = 2'd3
    } rate_e;

    localparam int PAY_W = 8;
    localparam int CM_W  = PAY_W + 4;

    // Per-output-channel connection word.
    typedef struct packed {
        logic             drive_en;
        logic             force_hi;
        logic             msg_mode;
        logic             var_delay;
        logic [PAY_W-1:0] payload;
    } cm_word_t;

    // Mask of the sub-slot clock bits for a rate code.
    function automatic logic [15:0] sub_slot_mask(input logic [1:0] code);
        return ~(16'hFFFF << code);
    endfunction

endpackage

// File: rtl/tsi_frame_ctr.sv
module tsi_frame_ctr
    import tsi_pkg::*;
#(
    parameter int FRAME = 128,
    parameter int PW    = $clog2(FRAME)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fp_in,
    output logic [PW-1:0] pos,
    output logic          half
);

    logic [PW-1:0] cnt_q;
    logic          half_q;
    logic          frame_start;

    always_comb begin
        if (fp_in || cnt_q == PW'(FRAME - 1)) begin
            pos = '0;
        end else begin
            pos = cnt_q + 1'b1;
        end
        frame_start = (pos == '0);
        half        = frame_start ? ~half_q : half_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= PW'(FRAME - 1);
            half_q <= 1'b0;
        end else begin
            cnt_q  <= pos;
            half_q <= half;
        end
    end

endmodule

// File: rtl/tsi_rx.sv
module tsi_rx
    import tsi_pkg::*;
#(
    parameter int PW  = 7,
    parameter int CHW = 4,
    parameter int NS  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PW-1:0]       pos,
    input  logic [1:0]          rate,
    input  logic [NS-1:0]       din,
    output logic                wr_en,
    output logic [CHW-1:0]      wr_ch,
    output logic [NS-1:0][7:0]  wr_byte
);

    logic [PW-1:0] idx;
    logic          aligned;
    logic [6:0]    sh_q [NS];

    always_comb begin
        aligned = ((16'(pos) & sub_slot_mask(rate)) == 16'd0);
        idx     = pos >> rate;
        wr_en   = aligned && (idx[2:0] == 3'd7);
        wr_ch   = idx[PW-1:3];
        for (int s = 0; s < NS; s++) begin
            wr_byte[s] = {sh_q[s], din[s]};
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < NS; s++) begin
            if (rst) begin
                sh_q[s] <= '0;
            end else if (aligned) begin
                sh_q[s] <= {sh_q[s][5:0], din[s]};
            end
        end
    end

endmodule

// File: rtl/tsi_tx.sv
module tsi_tx
    import tsi_pkg::*;
#(
    parameter int PW  = 7,
    parameter int CHW = 4,
    parameter int NS  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PW-1:0]       pos,
    input  logic [1:0]          rate,
    input  cm_word_t [NS-1:0]   ld_word,
    input  logic [NS-1:0][7:0]  ld_byte,
    output logic [CHW-1:0]      rd_ch,
    output logic [NS-1:0]       out_data,
    output logic [NS-1:0]       out_en
);

    logic [PW-1:0] idx;
    logic          aligned;
    logic          load;
    logic [2:0]    bitn;

    always_comb begin
        aligned = ((16'(pos) & sub_slot_mask(rate)) == 16'd0);
        idx     = pos >> rate;
        bitn    = idx[2:0];
        load    = aligned && (bitn == 3'd0);
        rd_ch   = idx[PW-1:3];
    end

    for (genvar s = 0; s < NS; s++) begin : g_lane
        logic [7:0] byte_q;
        logic       en_q;
        logic       fh_q;
        logic       dq_q;
        logic       oe_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '0;
                en_q   <= 1'b0;
                fh_q   <= 1'b0;
                dq_q   <= 1'b0;
                oe_q   <= 1'b0;
            end else if (load) begin
                byte_q <= ld_byte[s];
                en_q   <= ld_word[s].drive_en;
                fh_q   <= ld_word[s].force_hi;
                oe_q   <= ld_word[s].drive_en;
                dq_q   <= ld_word[s].drive_en &
                          (ld_word[s].force_hi | ld_byte[s][7]);
            end else if (aligned) begin
                dq_q   <= en_q & (fh_q | byte_q[3'd7 - bitn]);
            end
        end

        assign out_data[s] = dq_q;
        assign out_en[s]   = oe_q;
    end

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int CH_MAX = 16,
    parameter int FRAME  = CH_MAX * 8,
    parameter int PW     = $clog2(FRAME),
    parameter int CHW    = $clog2(CH_MAX)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fp_in,
    input  logic [1:0]      in_rate,
    input  logic [1:0]      out_rate,
    input  logic [1:0]      rx_data,
    input  logic            cm_we,
    input  logic [CHW:0]    cm_addr,
    input  logic [11:0]     cm_wdata,
    output logic [1:0]      tx_data,
    output logic [1:0]      tx_en
);

    localparam int NS = 2;

    logic [PW-1:0]        pos;
    logic                 half;
    logic                 wr_en;
    logic [CHW-1:0]       wr_ch;
    logic [NS-1:0][7:0]   wr_byte;
    logic [CHW-1:0]       rd_ch;
    cm_word_t [NS-1:0]    ld_word;
    logic [NS-1:0][7:0]   ld_byte;

    cm_word_t   cm_q   [NS][CH_MAX];
    logic [7:0] dmem_q [2][NS][CH_MAX];

    tsi_frame_ctr #(.FRAME(FRAME), .PW(PW)) u_ctr (
        .clk(clk), .rst(rst), .fp_in(fp_in), .pos(pos), .half(half)
    );

    tsi_rx #(.PW(PW), .CHW(CHW), .NS(NS)) u_rx (
        .clk(clk), .rst(rst), .pos(pos), .rate(in_rate), .din(rx_data),
        .wr_en(wr_en), .wr_ch(wr_ch), .wr_byte(wr_byte)
    );

    tsi_tx #(.PW(PW), .CHW(CHW), .NS(NS)) u_tx (
        .clk(clk), .rst(rst), .pos(pos), .rate(out_rate),
        .ld_word(ld_word), .ld_byte(ld_byte), .rd_ch(rd_ch),
        .out_data(tx_data), .out_en(tx_en)
    );

    // Connection memory: one word per output stream and channel.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NS; s++)
                for (int c = 0; c < CH_MAX; c++)
                    cm_q[s][c] <= '0;
        end else if (cm_we) begin
            cm_q[cm_addr[CHW]][cm_addr[CHW-1:0]] <= cm_word_t'(cm_wdata);
        end
    end

    // Double-buffered data memory; 'half' is written this frame.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int h = 0; h < 2; h++)
                for (int s = 0; s < NS; s++)
                    for (int c = 0; c < CH_MAX; c++)
                        dmem_q[h][s][c] <= '0;
        end else if (wr_en) begin
            for (int s = 0; s < NS; s++)
                dmem_q[half][s][wr_ch] <= wr_byte[s];
        end
    end

    // Per-output-stream source selection.
    for (genvar s = 0; s < NS; s++) begin : g_sel
        cm_word_t        w;
        logic            src_s;
        logic [CHW-1:0]  src_c;
        logic [PW+2:0]   last_slot;
        logic            seen;
        logic            rd_half;

        assign w         = cm_q[s][rd_ch];
        assign src_s     = w.payload[CHW];
        assign src_c     = w.payload[CHW-1:0];
        assign last_slot = (PW+3)'({src_c, 3'b111}) << in_rate;
        assign seen      = (PW+3)'(pos) > last_slot;
        assign rd_half   = (w.var_delay && seen) ? half : ~half;
        assign ld_word[s] = w;
        assign ld_byte[s] = w.msg_mode ? w.payload
                                       : dmem_q[rd_half][src_s][src_c];
    end

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
    import tsi_pkg::*;
#(
    parameter int PW = 7
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    tx_data,
    input logic [1:0]    tx_en,
    input logic [1:0]    in_rate,
    input logic [1:0]    out_rate,
    input logic [PW-1:0] pos,
    input logic          wr_en
);

    // R1: reset leaves every output disabled.
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (tx_en == 2'b00 && tx_data == 2'b00));

    // R5: a disabled output never shows a one.
    p_off_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        ((tx_data & ~tx_en) == 2'b00));

    // R3: outputs hold for the whole bit slot.
    p_slot_hold_r3: assert property (@(posedge clk) disable iff (rst)
        ((16'(pos) & sub_slot_mask(out_rate)) != 16'd0)
        |=> ($stable(tx_data) && $stable(tx_en)));

    // R2: byte writes fall on slot starts and never at frame position 0.
    p_write_slot_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (((16'(pos) & sub_slot_mask(in_rate)) == 16'd0)
                   && pos != '0));

endmodule

bind tsi_switch tsi_switch_chk #(.PW(PW)) u_chk (
    .clk(clk), .rst(rst), .tx_data(tx_data), .tx_en(tx_en),
    .in_rate(in_rate), .out_rate(out_rate), .pos(pos), .wr_en(wr_en)
);

// File: tb/tsi_switch_bench.sv
module tsi_switch_bench;

    localparam int CH_MAX = 16;
    localparam int FRAME  = CH_MAX * 8;
    localparam int CHW    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fp_in = 1'b0;
    logic [1:0]  in_rate = 2'd0;
    logic [1:0]  out_rate = 2'd0;
    logic [1:0]  rx_data = 2'd0;
    logic        cm_we = 1'b0;
    logic [CHW:0] cm_addr = '0;
    logic [11:0] cm_wdata = '0;
    logic [1:0]  tx_data;
    logic [1:0]  tx_en;

    int checks = 0;
    int failures = 0;
    int unsigned seed = 32'h1234_5678;
    logic [11:0] cmw [2][CH_MAX];

    tsi_switch #(.CH_MAX(CH_MAX)) u_tsi_switch (
        .clk(clk), .rst(rst), .fp_in(fp_in), .in_rate(in_rate),
        .out_rate(out_rate), .rx_data(rx_data), .cm_we(cm_we),
        .cm_addr(cm_addr), .cm_wdata(cm_wdata), .tx_data(tx_data),
        .tx_en(tx_en)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] gen(input int fr, input int s, input int c);
        if (fr < 0) return 8'h00;
        return 8'((fr * 53 + s * 97 + c * 29 + 11) & 255);
    endfunction

    function automatic int unsigned next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got en/data=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    // Expected {en,data} for output stream s, channel oc, bit b, frame fr.
    task automatic expect_bit(input int s, input int oc, input int b, input int fr,
                              input int ri, input int ro,
                              output logic [1:0] exp, output string tag);
        logic [11:0] w;
        int ss, sc, pstart, lw, f;
        logic [7:0] byt;
        w = cmw[s][oc];
        if (!w[11]) begin
            exp = 2'b00; tag = "R5 R4";
        end else if (w[10]) begin
            exp = 2'b11; tag = "R6 R4";
        end else if (w[9]) begin
            exp = {1'b1, w[7 - b]}; tag = "R7 R4";
        end else begin
            ss = int'(w[CHW]);
            sc = int'(w[CHW-1:0]);
            pstart = (oc * 8) << ro;
            lw = (sc * 8 + 7) << ri;
            if (w[8] && pstart > lw) f = fr; else f = fr - 1;
            byt = gen(f, ss, sc);
            exp = {1'b1, byt[7 - b]};
            tag = w[8] ? "R9 R10 R2 R3" : "R8 R10 R2 R3";
        end
    endtask

    initial begin
        #4ms;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int ri = 0; ri < 4; ri++) begin
            for (int ro = 0; ro < 4; ro++) begin
                int prev_p;
                int prev_fr;
                logic prev_ok;
                rst = 1'b1;
                cm_we = 1'b0;
                fp_in = 1'b0;
                in_rate = 2'(ri);
                out_rate = 2'(ro);
                repeat (3) @(negedge clk);
                check("R1 reset", {tx_en[0], tx_data[0]}, 2'b00);
                check("R1 reset", {tx_en[1], tx_data[1]}, 2'b00);
                for (int s = 0; s < 2; s++) begin
                    for (int c = 0; c < CH_MAX; c++) begin
                        int unsigned r;
                        int sc;
                        r = next_rand();
                        cmw[s][c][11] = (r[2:0] != 3'd0);
                        cmw[s][c][10] = (r[5:3] == 3'd0);
                        cmw[s][c][9]  = (r[7:6] == 2'd0);
                        cmw[s][c][8]  = r[8];
                        if (cmw[s][c][9]) begin
                            cmw[s][c][7:0] = r[23:16];
                        end else begin
                            sc = int'(r[19:16]) % (CH_MAX >> ri);
                            cmw[s][c][7:0] = {3'b000, r[20], 4'(sc)};
                        end
                    end
                end
                prev_ok = 1'b0;
                prev_p = 0;
                prev_fr = 0;
                for (int fr = 0; fr < 4; fr++) begin
                    for (int p = 0; p < FRAME; p++) begin
                        int bi, c, bt;
                        @(negedge clk);
                        rst = 1'b0;
                        // Outputs now show the slot that started at prev_p.
                        if (prev_ok && prev_fr >= 1 &&
                            (prev_p % (1 << ro)) == 0) begin
                            int ob, oc, obit;
                            ob = prev_p >> ro;
                            oc = ob >> 3;
                            obit = ob & 7;
                            for (int s = 0; s < 2; s++) begin
                                logic [1:0] exp;
                                string tag;
                                expect_bit(s, oc, obit, prev_fr, ri, ro, exp, tag);
                                check(tag, {tx_en[s], tx_data[s]}, exp);
                            end
                        end
                        fp_in = (p == 0);
                        bi = p >> ri;
                        c = bi >> 3;
                        bt = bi & 7;
                        for (int s = 0; s < 2; s++) begin
                            logic [7:0] byt;
                            byt = gen(fr, s, c);
                            rx_data[s] = byt[7 - bt];
                        end
                        if (fr == 0 && p < 2 * CH_MAX) begin
                            cm_we = 1'b1;
                            cm_addr = (CHW+1)'(p);
                            cm_wdata = cmw[p / CH_MAX][p % CH_MAX];
                        end else begin
                            cm_we = 1'b0;
                        end
                        prev_ok = 1'b1;
                        prev_p = p;
                        prev_fr = fr;
                    end
                end
                @(negedge clk);
                rst = 1'b1;
                cm_we = 1'b0;
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule